// File: doc/BRIEF.md
# System Power Mode Controller

This block steps a system through four power modes, named sleep, doze, slow and normal. Software requests a mode by writing a small mode field. For each mode the block drives the clock enables for the CPU and the system bus, the power enable of the PLL, the choice between the PLL output and the crystal reference, and the divider setting applied to the reference. It also tells the clock tree to run the controller itself from the low-speed oscillator while the system sleeps. The mode now in effect is reported back in a status field.

Sleep can only be left in hardware. Either interrupt request line wakes the system into slow mode, and from there software has to ask for normal again. Entering normal is done in two steps: the PLL is powered first, and the clock source changes over only after the PLL reports lock or a programmable wait runs out. Leaving normal reverses those steps: the source moves back to the reference one cycle before the PLL is powered down. The reference divider setting is tracked only while the reference drives the system, so it cannot change while the PLL is selected.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: After reset the block is in slow mode. Both clock enables are 1, the PLL is off, the reference is selected, the divider output is 00 and the status reads 010.
- R2: A write with `mode_wr` high decodes `mode_req` as follows: 000 is sleep, 001 is doze, 010 and 011 are slow, and any value 1xx is normal. The status codes are 000 sleep, 001 doze, 010 slow and 100 normal.
- R3: In sleep, both clock enables are 0, the PLL is off, the reference is selected and `lowosc_sel` is 1. `lowosc_sel` is 0 in every other state.
- R4: Doze turns off only the CPU clock enable. Slow turns on both clock enables and keeps the PLL off.
- R5: Sleep is left only at a clock edge where `fiq_req` or `irq_req` is high, and it is left for slow mode. Mode writes made during sleep have no effect.
- R6: A normal request from doze or slow powers the PLL while the reference stays selected. The source moves to the PLL at the first edge that sees `pll_lock` high.
- R7: If lock never arrives, the source moves to the PLL after LOCK_TIMEOUT edges spent waiting.
- R8: A request for a lower mode made in normal first gives one cycle in which the reference is selected and the PLL is still on. The requested mode and PLL off follow on the next edge.
- R9: Mode writes are ignored while the PLL is starting up or shutting down.
- R10: `ref_div_out` takes the value of `ref_div_sel` (00 is /1, 01 is /2, 10 is /4, 11 is /8) one edge later whenever the PLL is not selected. It holds its value while the PLL is selected.
- R11: In normal, both clock enables and the PLL are on, the PLL is selected and the status reads 100.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode_wr | input | 1 | Strobe for a software mode write |
| mode_req | input | 3 | Requested mode code |
| ref_div_sel | input | 2 | Requested reference divider |
| fiq_req | input | 1 | Fast interrupt request |
| irq_req | input | 1 | Normal interrupt request |
| pll_lock | input | 1 | PLL lock indication, already synchronous |
| cpu_clk_en | output | 1 | CPU clock enable |
| bus_clk_en | output | 1 | System bus clock enable |
| pll_en | output | 1 | PLL power enable |
| src_pll_sel | output | 1 | 1 selects the PLL, 0 selects the reference |
| ref_div_out | output | 2 | Divider applied to the reference |
| lowosc_sel | output | 1 | Run the controller from the low-speed oscillator |
| mode_stat | output | 3 | Mode now in effect |

## Verification
The hardest states to reach from the ports are the two short transitional states. The shutdown step exists for exactly one cycle. The startup wait lasts until lock or the timeout. The stimulus writes a new mode inside each of these windows and expects the write to be lost. During the shutdown step it also changes the divider select, which shows that the divider is sampled again as soon as the reference is back in use. The timeout path is covered by holding lock low across a reduced LOCK_TIMEOUT and checking the output on every cycle of the wait.

// File: rtl/pmc_pkg.sv
package pmc_pkg;

    typedef enum logic [2:0] {
        PM_SLEEP   = 3'd0,
        PM_DOZE    = 3'd1,
        PM_SLOW    = 3'd2,
        PM_PLLWAIT = 3'd3,
        PM_NORMAL  = 3'd4,
        PM_PLLEXIT = 3'd5
    } pm_state_e;

    localparam logic [2:0] STAT_SLEEP  = 3'b000;
    localparam logic [2:0] STAT_DOZE   = 3'b001;
    localparam logic [2:0] STAT_SLOW   = 3'b010;
    localparam logic [2:0] STAT_NORMAL = 3'b100;

    // Turn a software mode code into a stable target state.
    function automatic pm_state_e decode_req(input logic [2:0] code);
        pm_state_e t;
        if (code[2])              t = PM_NORMAL;
        else if (code[1])         t = PM_SLOW;
        else if (code[0])         t = PM_DOZE;
        else                      t = PM_SLEEP;
        return t;
    endfunction

endpackage

// File: rtl/pmc_lock_timer.sv
module pmc_lock_timer #(
    parameter int LOCK_TIMEOUT = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    input  logic lock_i,
    output logic done_o
);
    localparam int CW = (LOCK_TIMEOUT > 2) ? $clog2(LOCK_TIMEOUT) : 1;
    localparam logic [CW-1:0] LAST = CW'(LOCK_TIMEOUT - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } tmr_t;

    tmr_t tmr_d, tmr_q;

    always_comb begin
        tmr_d = tmr_q;
        if (run_i && tmr_q.cnt != LAST) tmr_d.cnt = tmr_q.cnt + 1'b1;
        if (!run_i)                     tmr_d.cnt = '0;
        done_o = run_i && (lock_i || tmr_q.cnt == LAST);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tmr_q <= '0;
        else        tmr_q <= tmr_d;
    end

    // R7: the wait counter never exceeds the timeout bound
    assert_timer_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_q.cnt <= LAST);

    // R7: the counter is cleared whenever the wait was not active
    assert_timer_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(run_i) |-> tmr_q.cnt == '0);

endmodule

// File: rtl/pmc_ref_div.sv
module pmc_ref_div #(
    parameter int DW = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          hold_i,
    input  logic [DW-1:0] sel_i,
    output logic [DW-1:0] sel_o
);
    typedef struct packed {
        logic [DW-1:0] sel;
    } div_t;

    div_t div_d, div_q;

    always_comb begin
        div_d = div_q;
        if (!hold_i) div_d.sel = sel_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) div_q <= '0;
        else        div_q <= div_d;
    end

    assign sel_o = div_q.sel;

    // R10: frozen while the PLL drives the system
    assert_div_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $past(hold_i) |-> div_q.sel == $past(div_q.sel));

    // R10: follows the select while the reference is in use
    assert_div_track_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(hold_i) |-> div_q.sel == $past(sel_i));

endmodule

// File: rtl/pmc_mode_fsm.sv
module pmc_mode_fsm
    import pmc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_i,
    input  logic [2:0] req_i,
    input  logic       wake_i,
    input  logic       pll_ready_i,
    output logic       waiting_o,
    output logic       cpu_en_o,
    output logic       bus_en_o,
    output logic       pll_en_o,
    output logic       src_pll_o,
    output logic       lowosc_o,
    output logic [2:0] stat_o
);
    typedef struct packed {
        pm_state_e st;
        pm_state_e target;
    } fsm_t;

    fsm_t fsm_d, fsm_q;
    pm_state_e want;

    always_comb begin
        fsm_d = fsm_q;
        want  = decode_req(req_i);
        unique case (fsm_q.st)
            PM_SLEEP: begin
                if (wake_i) fsm_d.st = PM_SLOW;
            end
            PM_DOZE, PM_SLOW: begin
                if (wr_i) begin
                    if (want == PM_NORMAL) fsm_d.st = PM_PLLWAIT;
                    else                   fsm_d.st = want;
                end
            end
            PM_PLLWAIT: begin
                if (pll_ready_i) fsm_d.st = PM_NORMAL;
            end
            PM_NORMAL: begin
                if (wr_i && want != PM_NORMAL) begin
                    fsm_d.st     = PM_PLLEXIT;
                    fsm_d.target = want;
                end
            end
            PM_PLLEXIT: begin
                fsm_d.st = fsm_q.target;
            end
            default: fsm_d.st = PM_SLOW;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fsm_q.st     <= PM_SLOW;
            fsm_q.target <= PM_SLOW;
        end else begin
            fsm_q <= fsm_d;
        end
    end

    always_comb begin
        cpu_en_o  = 1'b1;
        bus_en_o  = 1'b1;
        pll_en_o  = 1'b0;
        src_pll_o = 1'b0;
        lowosc_o  = 1'b0;
        stat_o    = STAT_SLOW;
        waiting_o = 1'b0;
        unique case (fsm_q.st)
            PM_SLEEP: begin
                cpu_en_o = 1'b0;
                bus_en_o = 1'b0;
                lowosc_o = 1'b1;
                stat_o   = STAT_SLEEP;
            end
            PM_DOZE: begin
                cpu_en_o = 1'b0;
                stat_o   = STAT_DOZE;
            end
            PM_PLLWAIT: begin
                pll_en_o  = 1'b1;
                waiting_o = 1'b1;
            end
            PM_NORMAL: begin
                pll_en_o  = 1'b1;
                src_pll_o = 1'b1;
                stat_o    = STAT_NORMAL;
            end
            PM_PLLEXIT: begin
                pll_en_o = 1'b1;
                stat_o   = STAT_NORMAL;
            end
            default: ;
        endcase
    end

    // R5: sleep is left only when an interrupt was seen at that edge
    assert_sleep_exit_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(fsm_q.st) == PM_SLEEP && fsm_q.st != PM_SLEEP) |-> $past(wake_i));

    // R5: a wake always lands in slow mode
    assert_wake_slow_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(fsm_q.st) == PM_SLEEP && $past(wake_i)) |-> fsm_q.st == PM_SLOW);

    // R6: the source switches to the PLL only after it was already powered
    assert_src_after_pll_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(src_pll_o) |-> $past(pll_en_o));

    // R8: the PLL powers down only after the reference was already selected
    assert_pll_off_order_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pll_en_o) |-> !$past(src_pll_o));

    // R9: the startup wait is left only toward normal
    assert_wait_exit_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(fsm_q.st) == PM_PLLWAIT && fsm_q.st != PM_PLLWAIT) |-> fsm_q.st == PM_NORMAL);

endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl #(
    parameter int LOCK_TIMEOUT = 64,
    parameter int DIV_W        = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mode_wr,
    input  logic [2:0]       mode_req,
    input  logic [DIV_W-1:0] ref_div_sel,
    input  logic             fiq_req,
    input  logic             irq_req,
    input  logic             pll_lock,
    output logic             cpu_clk_en,
    output logic             bus_clk_en,
    output logic             pll_en,
    output logic             src_pll_sel,
    output logic [DIV_W-1:0] ref_div_out,
    output logic             lowosc_sel,
    output logic [2:0]       mode_stat
);
    logic wake;
    logic waiting;
    logic pll_ready;

    assign wake = fiq_req | irq_req;

    pmc_lock_timer #(.LOCK_TIMEOUT(LOCK_TIMEOUT)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_i  (waiting),
        .lock_i (pll_lock),
        .done_o (pll_ready)
    );

    pmc_mode_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_i        (mode_wr),
        .req_i       (mode_req),
        .wake_i      (wake),
        .pll_ready_i (pll_ready),
        .waiting_o   (waiting),
        .cpu_en_o    (cpu_clk_en),
        .bus_en_o    (bus_clk_en),
        .pll_en_o    (pll_en),
        .src_pll_o   (src_pll_sel),
        .lowosc_o    (lowosc_sel),
        .stat_o      (mode_stat)
    );

    pmc_ref_div #(.DW(DIV_W)) u_div (
        .clk    (clk),
        .rst_n  (rst_n),
        .hold_i (src_pll_sel),
        .sel_i  (ref_div_sel),
        .sel_o  (ref_div_out)
    );

    // R3: the low-speed oscillator is used only with the system clocks gated
    assert_lowosc_gated_R3: assert property (@(posedge clk) disable iff (!rst_n)
        lowosc_sel |-> (!cpu_clk_en && !bus_clk_en && !pll_en));

endmodule

// File: tb/pwr_mode_ctrl_bench.sv
module pwr_mode_ctrl_bench;
    localparam int T = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic mode_wr = 1'b0;
    logic [2:0] mode_req = 3'b0;
    logic [1:0] ref_div_sel = 2'b0;
    logic fiq_req = 1'b0, irq_req = 1'b0, pll_lock = 1'b0;
    logic cpu_clk_en, bus_clk_en, pll_en, src_pll_sel, lowosc_sel;
    logic [1:0] ref_div_out;
    logic [2:0] mode_stat;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    typedef struct {
        logic [9:0] v;
        string      tag;
    } exp_t;
    exp_t sb[$];

    always #4 clk = ~clk;

    pwr_mode_ctrl #(.LOCK_TIMEOUT(T)) u_pwr_mode_ctrl (
        .clk(clk), .rst_n(rst_n), .mode_wr(mode_wr), .mode_req(mode_req),
        .ref_div_sel(ref_div_sel), .fiq_req(fiq_req), .irq_req(irq_req),
        .pll_lock(pll_lock), .cpu_clk_en(cpu_clk_en), .bus_clk_en(bus_clk_en),
        .pll_en(pll_en), .src_pll_sel(src_pll_sel), .ref_div_out(ref_div_out),
        .lowosc_sel(lowosc_sel), .mode_stat(mode_stat)
    );

    // State numbers: 0 sleep, 1 doze, 2 slow, 3 pll wait, 4 normal, 5 pll exit
    function automatic logic [9:0] expv(input int st, input logic [1:0] d);
        logic [4:0] f;
        logic [2:0] s;
        case (st)
            0: begin f = 5'b00001; s = 3'b000; end
            1: begin f = 5'b01000; s = 3'b001; end
            3: begin f = 5'b11100; s = 3'b010; end
            4: begin f = 5'b11110; s = 3'b100; end
            5: begin f = 5'b11100; s = 3'b100; end
            default: begin f = 5'b11000; s = 3'b010; end
        endcase
        return {f, d, s};
    endfunction

    // Driver: apply one cycle of stimulus and push the expected result
    task automatic cyc(input bit wr, input logic [2:0] m, input logic [1:0] d,
                       input bit fq, input bit iq, input bit lk,
                       input int st, input logic [1:0] ed, input string tag);
        exp_t e;
        @(negedge clk);
        mode_wr = wr; mode_req = m; ref_div_sel = d;
        fiq_req = fq; irq_req = iq; pll_lock = lk;
        e.v = expv(st, ed);
        e.tag = tag;
        sb.push_back(e);
        @(posedge clk);
    endtask

    // Monitor: compare after each edge
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (sb.size() > 0) begin
                exp_t e;
                logic [9:0] a;
                e = sb.pop_front();
                a = {cpu_clk_en, bus_clk_en, pll_en, src_pll_sel, lowosc_sel,
                     ref_div_out, mode_stat};
                n_cmp++;
                if (a !== e.v) begin
                    n_bad++;
                    $display("FAIL %s: got %b expected %b", e.tag, a, e.v);
                end
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        cyc(0, 3'b000, 2'b00, 0, 0, 0, 2, 2'b00, "R1 reset state");
        cyc(0, 3'b000, 2'b01, 0, 0, 0, 2, 2'b01, "R10 divider tracks");
        cyc(1, 3'b001, 2'b01, 0, 0, 0, 1, 2'b01, "R2 R4 doze");
        cyc(1, 3'b000, 2'b01, 0, 0, 0, 0, 2'b01, "R3 sleep");
        cyc(1, 3'b010, 2'b01, 0, 0, 0, 0, 2'b01, "R5 write ignored in sleep");
        cyc(0, 3'b000, 2'b01, 0, 0, 0, 0, 2'b01, "R5 stays asleep");
        cyc(0, 3'b000, 2'b01, 0, 1, 0, 2, 2'b01, "R5 irq wake to slow");
        cyc(1, 3'b000, 2'b01, 0, 0, 0, 0, 2'b01, "R3 sleep again");
        cyc(0, 3'b000, 2'b01, 1, 0, 0, 2, 2'b01, "R5 fiq wake to slow");
        cyc(1, 3'b001, 2'b01, 0, 0, 0, 1, 2'b01, "R4 doze");
        cyc(1, 3'b011, 2'b01, 0, 0, 0, 2, 2'b01, "R2 code 011 is slow");
        cyc(1, 3'b110, 2'b10, 0, 0, 0, 3, 2'b10, "R6 pll on, reference kept");
        cyc(1, 3'b001, 2'b10, 0, 0, 0, 3, 2'b10, "R9 write ignored in wait");
        cyc(0, 3'b000, 2'b10, 0, 0, 1, 4, 2'b10, "R6 R11 lock selects pll");
        cyc(0, 3'b000, 2'b11, 0, 0, 0, 4, 2'b10, "R10 divider held on pll");
        cyc(1, 3'b000, 2'b11, 0, 0, 0, 5, 2'b10, "R8 reference before pll off");
        cyc(1, 3'b010, 2'b11, 0, 0, 0, 0, 2'b11, "R8 R9 exit lands in sleep");
        cyc(0, 3'b000, 2'b11, 0, 1, 0, 2, 2'b11, "R5 wake");
        cyc(1, 3'b100, 2'b11, 0, 0, 0, 3, 2'b11, "R7 wait entry");
        for (int k = 1; k < T; k++)
            cyc(0, 3'b000, 2'b11, 0, 0, 0, 3, 2'b11, "R7 still waiting");
        cyc(0, 3'b000, 2'b11, 0, 0, 0, 4, 2'b11, "R7 timeout selects pll");
        cyc(1, 3'b001, 2'b00, 0, 0, 0, 5, 2'b11, "R8 exit step");
        cyc(0, 3'b000, 2'b00, 0, 0, 0, 1, 2'b00, "R8 R4 doze after exit");
        @(posedge clk);
        #3;
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule